// File: doc/BRIEF.md
# Power-Stage Startup Sequencer With PWM Validity Monitor

This block sits on the controller side of a switching audio power stage and drives that stage's active-low reset line. It watches four control inputs: a gate-drive supply-good flag, a bridge supply-good flag, a modulator-ready flag and a shutdown request. From these it walks the stage through a fixed order. The reset is held low while the bootstrap capacitors precharge. The modulator is then told to stream PWM. Reset is released only once that stream has been measured and found to be a plausible switching signal.

The incoming PWM is synchronised and timed in system-clock cycles between rising edges. A period inside the frequency window counts as good. A run of good periods makes the stream valid, and any bad period, missing edge or over-long high phase makes it invalid again. On the way down, reset always falls first, and the modulator enable is withdrawn a fixed two cycles later. A bridge supply that comes up ahead of the gate supply is latched as a sequencing error that prevents start-up until the next system reset.

Top module: `pwrStageSeq`

## Requirements
- R1: While the synchronous active-low system reset `rstN` is low, and in the cycle after it, `stageRstN`, `pwmEn`, `pwmOk`, `pwmStuck` and `seqErr` are all 0 and the sequencer is idle.
- R2: `pwmIn` passes through a two-flop synchroniser. A period is the number of clock cycles between two consecutive rising edges seen after the synchroniser. A period is in window when it lies from MIN_CYC = CLK_FREQ_HZ/PWM_MAX_HZ to MAX_CYC = CLK_FREQ_HZ/PWM_MIN_HZ cycles inclusive (integer division).
- R3: `pwmOk` rises after GOOD_RUNS consecutive in-window periods. The first rising edge after reset or after a timeout gives no measurable period. One out-of-window period clears `pwmOk` in the cycle after the edge that ended it.
- R4: If no rising edge follows for more than MAX_CYC cycles, `pwmOk` clears.
- R5: If the synchronised PWM stays high for more than MAX_CYC cycles, `pwmStuck` is 1 until the input falls, and `pwmOk` clears on the next cycle.
- R6: From idle, `gateGood` with no shutdown request and no sequence error starts a precharge phase. `stageRstN` and `pwmEn` stay 0 for PRE_CYC = (CLK_FREQ_HZ/1e6)*PRECHARGE_US cycles. Loss of `gateGood` or a shutdown request during precharge returns the block to idle, and the count restarts.
- R7: After precharge, `pwmEn` is 1. `stageRstN` rises only in the cycle after `gateGood`, `bridgeGood`, `modReady` and `pwmOk` were all 1 with `pwmStuck` 0.
- R8: While running, loss of `modReady`, loss of `pwmOk`, or `pwmStuck` drops `stageRstN` one cycle later and leaves `pwmEn` at 1. The block then waits for the PWM again without a new precharge.
- R9: While running or waiting, a shutdown request or loss of `gateGood` (and, while running, loss of `bridgeGood`) drops `stageRstN` first. `pwmEn` falls exactly STOP_HOLD = 2 cycles later, and the block then returns to idle.
- R10: `seqErr` is set when `bridgeGood` rises while `gateGood` is 0. This includes `bridgeGood` being 1 in the first cycle after reset. `seqErr` stays set until the system reset and keeps the block idle.
- R11: While `shutdownReq` is 1, the block does not leave idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low system reset |
| gateGood | input | 1 | Gate-drive supply is good |
| bridgeGood | input | 1 | Bridge supply is good |
| modReady | input | 1 | Modulator is initialised |
| shutdownReq | input | 1 | Request to power the stage down |
| pwmIn | input | 1 | Raw PWM stream, asynchronous |
| stageRstN | output | 1 | Active-low reset to the power stage |
| pwmEn | output | 1 | Enable for the modulator's PWM output |
| pwmOk | output | 1 | PWM measured valid |
| pwmStuck | output | 1 | PWM held high too long |
| seqErr | output | 1 | Sticky supply-order error |

## Verification
The bench builds the block with a 4 MHz clock-frequency parameter, a 10 µs precharge and GOOD_RUNS = 4. This gives a window of 10 to 11 cycles and a 40-cycle precharge. With these values, both window edges and the periods just outside them (9 and 12 cycles) can be reached within a few hundred cycles. So can the precharge restart, the two-cycle enable hold and the error latch.

// File: rtl/pwrStageSeqPkg.sv
package pwrStageSeqPkg;

  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_PRECHARGE = 3'd1,
    ST_WAIT_PWM  = 3'd2,
    ST_RUN       = 3'd3,
    ST_STOP      = 3'd4
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic tmrClr;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic pwmOk;
    logic pwmStuck;
    logic preDone;
    logic holdOver;
  } dpStatus_t;

endpackage

// File: rtl/pwrStageSeqDp.sv
module pwrStageSeqDp
  import pwrStageSeqPkg::*;
#(
  parameter int MIN_CYC   = 250,
  parameter int MAX_CYC   = 285,
  parameter int GOOD_RUNS = 16,
  parameter int PRE_CYC   = 100000,
  parameter int STOP_HOLD = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwmIn,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status
);

  localparam int SAT     = MAX_CYC + 1;
  localparam int PER_W   = $clog2(SAT + 1);
  localparam int RUN_W   = $clog2(GOOD_RUNS + 1);
  localparam int TMR_TOP = (PRE_CYC > STOP_HOLD) ? PRE_CYC : STOP_HOLD;
  localparam int TMR_W   = $clog2(TMR_TOP + 1);

  localparam logic [PER_W-1:0] SAT_V    = PER_W'(SAT);
  localparam logic [PER_W-1:0] MIN_V    = PER_W'(MIN_CYC);
  localparam logic [PER_W-1:0] MAX_V    = PER_W'(MAX_CYC);
  localparam logic [RUN_W-1:0] RUN_TOP  = RUN_W'(GOOD_RUNS);
  localparam logic [TMR_W-1:0] TMR_TOPV = TMR_W'(TMR_TOP);
  localparam logic [TMR_W-1:0] PRE_LAST = TMR_W'(PRE_CYC - 1);
  localparam logic [TMR_W-1:0] HOLD_V   = TMR_W'(STOP_HOLD);

  logic [1:0]       syncQ;
  logic             pwmS;
  logic             pwmD;
  logic             pwmRise;
  logic             inWindow;
  logic             lostEdge;
  logic [PER_W-1:0] periodCnt;
  logic [PER_W-1:0] highCnt;
  logic [RUN_W-1:0] goodRun;
  logic [TMR_W-1:0] seqTmr;

  assign pwmS     = syncQ[1];
  assign pwmRise  = pwmS & ~pwmD;
  assign inWindow = (periodCnt >= MIN_V) && (periodCnt <= MAX_V);
  assign lostEdge = (periodCnt == SAT_V) || (highCnt == SAT_V);

  // input synchroniser and edge history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      pwmD  <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], pwmIn};
      pwmD  <= pwmS;
    end
  end

  // rising-edge period counter, saturated value means "no reference edge"
  always_ff @(posedge clk) begin
    if (!rstN)                 periodCnt <= SAT_V;
    else if (pwmRise)          periodCnt <= PER_W'(1);
    else if (periodCnt != SAT_V) periodCnt <= periodCnt + 1'b1;
  end

  // length of the current high phase
  always_ff @(posedge clk) begin
    if (!rstN || !pwmS)        highCnt <= '0;
    else if (highCnt != SAT_V) highCnt <= highCnt + 1'b1;
  end

  // run of consecutive in-window periods
  always_ff @(posedge clk) begin
    if (!rstN) begin
      goodRun <= '0;
    end else if (pwmRise) begin
      if (!inWindow)              goodRun <= '0;
      else if (goodRun != RUN_TOP) goodRun <= goodRun + 1'b1;
    end else if (lostEdge) begin
      goodRun <= '0;
    end
  end

  // shared sequencing timer, cleared on every state change
  always_ff @(posedge clk) begin
    if (!rstN || strobe.tmrClr) seqTmr <= '0;
    else if (seqTmr != TMR_TOPV) seqTmr <= seqTmr + 1'b1;
  end

  assign status.pwmOk    = (goodRun == RUN_TOP);
  assign status.pwmStuck = (highCnt == SAT_V);
  assign status.preDone  = (seqTmr == PRE_LAST);
  assign status.holdOver = (seqTmr >= HOLD_V);

endmodule

// File: rtl/pwrStageSeqCtrl.sv
module pwrStageSeqCtrl
  import pwrStageSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        gateGood,
  input  logic        bridgeGood,
  input  logic        modReady,
  input  logic        shutdownReq,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        stageRstN,
  output logic        pwmEn,
  output logic        seqErr
);

  seqState_t state;
  seqState_t stateNext;
  logic      bridgePrev;
  logic      pwmHealthy;

  assign pwmHealthy = status.pwmOk & ~status.pwmStuck;

  always_comb begin
    stateNext = state;
    case (state)
      ST_OFF:
        if (gateGood && !seqErr && !shutdownReq) stateNext = ST_PRECHARGE;
      ST_PRECHARGE:
        if (!gateGood || shutdownReq) stateNext = ST_OFF;
        else if (status.preDone)      stateNext = ST_WAIT_PWM;
      ST_WAIT_PWM:
        if (!gateGood || shutdownReq)                   stateNext = ST_STOP;
        else if (bridgeGood && modReady && pwmHealthy)  stateNext = ST_RUN;
      ST_RUN:
        if (shutdownReq || !gateGood || !bridgeGood) stateNext = ST_STOP;
        else if (!modReady || !pwmHealthy)           stateNext = ST_WAIT_PWM;
      ST_STOP:
        if (status.holdOver) stateNext = ST_OFF;
      default:
        stateNext = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  // supply-order error latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bridgePrev <= 1'b0;
      seqErr     <= 1'b0;
    end else begin
      bridgePrev <= bridgeGood;
      if (bridgeGood && !bridgePrev && !gateGood) seqErr <= 1'b1;
    end
  end

  assign strobe.tmrClr = (stateNext != state);
  assign stageRstN     = (state == ST_RUN);
  assign pwmEn         = (state == ST_WAIT_PWM) || (state == ST_RUN) ||
                         ((state == ST_STOP) && !status.holdOver);

endmodule

// File: rtl/pwrStageSeq.sv
module pwrStageSeq
  import pwrStageSeqPkg::*;
#(
  parameter int CLK_FREQ_HZ  = 100_000_000,
  parameter int PWM_MIN_HZ   = 350_000,
  parameter int PWM_MAX_HZ   = 400_000,
  parameter int PRECHARGE_US = 1000,
  parameter int GOOD_RUNS    = 16,
  parameter int STOP_HOLD    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic gateGood,
  input  logic bridgeGood,
  input  logic modReady,
  input  logic shutdownReq,
  input  logic pwmIn,
  output logic stageRstN,
  output logic pwmEn,
  output logic pwmOk,
  output logic pwmStuck,
  output logic seqErr
);

  localparam int MIN_CYC = CLK_FREQ_HZ / PWM_MAX_HZ;
  localparam int MAX_CYC = CLK_FREQ_HZ / PWM_MIN_HZ;
  localparam int PRE_CYC = (CLK_FREQ_HZ / 1_000_000) * PRECHARGE_US;

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  pwrStageSeqDp #(
    .MIN_CYC  (MIN_CYC),
    .MAX_CYC  (MAX_CYC),
    .GOOD_RUNS(GOOD_RUNS),
    .PRE_CYC  (PRE_CYC),
    .STOP_HOLD(STOP_HOLD)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .pwmIn (pwmIn),
    .strobe(strobe),
    .status(status)
  );

  pwrStageSeqCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .gateGood   (gateGood),
    .bridgeGood (bridgeGood),
    .modReady   (modReady),
    .shutdownReq(shutdownReq),
    .status     (status),
    .strobe     (strobe),
    .stageRstN  (stageRstN),
    .pwmEn      (pwmEn),
    .seqErr     (seqErr)
  );

  assign pwmOk    = status.pwmOk;
  assign pwmStuck = status.pwmStuck;

endmodule

// File: rtl/pwrStageSeqChk.sv
module pwrStageSeqChk (
  input logic clk,
  input logic rstN,
  input logic gateGood,
  input logic bridgeGood,
  input logic modReady,
  input logic stageRstN,
  input logic pwmEn,
  input logic pwmOk,
  input logic pwmStuck,
  input logic seqErr
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (!stageRstN && !pwmEn && !pwmOk && !seqErr));

  // R7
  release_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stageRstN) |-> $past(gateGood && bridgeGood && modReady && pwmOk && !pwmStuck));

  // R7
  run_has_pwm_chk: assert property (@(posedge clk) disable iff (!rstN)
    stageRstN |-> pwmEn);

  // R9
  reset_before_pwm_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(stageRstN) && $past(rstN)) |=> pwmEn);

  // R5
  stuck_clears_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwmStuck |=> !pwmOk);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(seqErr)) |-> seqErr);

endmodule

bind pwrStageSeq pwrStageSeqChk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .gateGood  (gateGood),
  .bridgeGood(bridgeGood),
  .modReady  (modReady),
  .stageRstN (stageRstN),
  .pwmEn     (pwmEn),
  .pwmOk     (pwmOk),
  .pwmStuck  (pwmStuck),
  .seqErr    (seqErr)
);

// File: tb/pwrStageSeq_tb_top.sv
module pwrStageSeq_tb_top;

  localparam int CLK_HZ = 4_000_000;
  localparam int FMIN   = 350_000;
  localparam int FMAX   = 400_000;
  localparam int PRE_US = 10;
  localparam int RUNS   = 4;
  localparam int HOLD   = 2;
  localparam int MINP   = CLK_HZ / FMAX;
  localparam int MAXP   = CLK_HZ / FMIN;
  localparam int PREC   = (CLK_HZ / 1_000_000) * PRE_US;
  localparam int TOP    = (PREC > HOLD) ? PREC : HOLD;

  logic clk = 1'b0;
  logic rstN = 1'b0, gateGood = 1'b0, bridgeGood = 1'b0, modReady = 1'b0;
  logic shutdownReq = 1'b0, pwmIn = 1'b0;
  logic stageRstN, pwmEn, pwmOk, pwmStuck, seqErr;

  always #10 clk = ~clk;

  pwrStageSeq #(
    .CLK_FREQ_HZ(CLK_HZ), .PWM_MIN_HZ(FMIN), .PWM_MAX_HZ(FMAX),
    .PRECHARGE_US(PRE_US), .GOOD_RUNS(RUNS), .STOP_HOLD(HOLD)
  ) dut_i (
    .clk(clk), .rstN(rstN), .gateGood(gateGood), .bridgeGood(bridgeGood),
    .modReady(modReady), .shutdownReq(shutdownReq), .pwmIn(pwmIn),
    .stageRstN(stageRstN), .pwmEn(pwmEn), .pwmOk(pwmOk),
    .pwmStuck(pwmStuck), .seqErr(seqErr)
  );

  int vectors = 0, miscompares = 0;
  string curTag = "R1";

  // reference model state (0 idle,1 precharge,2 wait,3 run,4 stop)
  int pipeQ[$];
  int mD = 0, mPer = MAXP + 1, mHigh = 0, mRun = 0;
  int mSt = 0, mTmr = 0, mErr = 0, mBp = 0;

  // PWM generator
  int genMode = 0, hiC = 5, loC = 5, nextHi = 5, nextLo = 5, ph = 0;

  task automatic modelReset();
    pipeQ = '{0, 0};
    mD = 0; mPer = MAXP + 1; mHigh = 0; mRun = 0;
    mSt = 0; mTmr = 0; mErr = 0; mBp = 0;
  endtask

  task automatic modelStep();
    int ok, nxt, s2, rise;
    if (!rstN) begin
      modelReset();
      return;
    end
    ok  = (mRun == RUNS) && (mHigh != MAXP + 1);
    nxt = mSt;
    case (mSt)
      0: if (gateGood && !mErr && !shutdownReq) nxt = 1;
      1: if (!gateGood || shutdownReq) nxt = 0;
         else if (mTmr == PREC - 1) nxt = 2;
      2: if (!gateGood || shutdownReq) nxt = 4;
         else if (bridgeGood && modReady && ok) nxt = 3;
      3: if (shutdownReq || !gateGood || !bridgeGood) nxt = 4;
         else if (!modReady || !ok) nxt = 2;
      default: if (mTmr >= HOLD) nxt = 0;
    endcase
    if (bridgeGood && !mBp && !gateGood) mErr = 1;
    mBp = int'(bridgeGood);
    s2 = pipeQ[0];
    rise = s2 && !mD;
    if (rise) mRun = (mPer >= MINP && mPer <= MAXP) ? ((mRun < RUNS) ? mRun + 1 : RUNS) : 0;
    else if (mPer == MAXP + 1 || mHigh == MAXP + 1) mRun = 0;
    if (rise) mPer = 1; else if (mPer < MAXP + 1) mPer++;
    if (!s2) mHigh = 0; else if (mHigh < MAXP + 1) mHigh++;
    mD = s2;
    void'(pipeQ.pop_front());
    pipeQ.push_back(int'(pwmIn));
    if (nxt != mSt) mTmr = 0; else if (mTmr < TOP) mTmr++;
    mSt = nxt;
  endtask

  task automatic cmp(string name, int got, int exp);
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d", curTag, name, got, exp);
    end
  endtask

  task automatic compareAll();
    vectors++;
    cmp("stageRstN", int'(stageRstN), int'(mSt == 3));
    cmp("pwmEn", int'(pwmEn), int'(mSt == 2 || mSt == 3 || (mSt == 4 && mTmr < HOLD)));
    cmp("pwmOk", int'(pwmOk), int'(mRun == RUNS));
    cmp("pwmStuck", int'(pwmStuck), int'(mHigh == MAXP + 1));
    cmp("seqErr", int'(seqErr), mErr);
  endtask

  // spot check against a value fixed by the requirement
  task automatic chk(string tag, string name, logic got, logic exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d", tag, name, got, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      if (genMode == 1) begin
        if (ph == 0) begin hiC = nextHi; loC = nextLo; end
        pwmIn = (ph < hiC);
        ph = (ph + 1 >= hiC + loC) ? 0 : ph + 1;
      end else begin
        pwmIn = (genMode == 2);
      end
      @(posedge clk);
      modelStep();
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic setPer(int h, int l);
    nextHi = h; nextLo = l;
  endtask

  initial begin
    modelReset();
    @(negedge clk);
    curTag = "R1";
    cyc(4);
    chk("R1", "stageRstN", stageRstN, 1'b0);
    chk("R1", "pwmEn", pwmEn, 1'b0);
    chk("R1", "seqErr", seqErr, 1'b0);
    rstN = 1'b1;
    cyc(5);

    curTag = "R2";
    genMode = 1; ph = 0; setPer(5, 5);
    cyc(80);
    chk("R2", "pwmOk period 10", pwmOk, 1'b1);

    curTag = "R6";
    gateGood = 1'b1; bridgeGood = 1'b1; modReady = 1'b0;
    cyc(20);
    gateGood = 1'b0;
    cyc(1);
    gateGood = 1'b1;
    cyc(PREC - 1);
    chk("R6", "pwmEn in precharge", pwmEn, 1'b0);
    chk("R6", "stageRstN in precharge", stageRstN, 1'b0);
    curTag = "R7";
    cyc(2);
    chk("R7", "pwmEn after precharge", pwmEn, 1'b1);
    chk("R7", "stageRstN without modReady", stageRstN, 1'b0);
    cyc(10);
    modReady = 1'b1;
    cyc(2);
    chk("R7", "stageRstN released", stageRstN, 1'b1);

    curTag = "R2";
    setPer(6, 5);
    cyc(60);
    chk("R2", "stageRstN period 11", stageRstN, 1'b1);

    curTag = "R3";
    setPer(6, 6);
    cyc(40);
    chk("R3", "pwmOk period 12", pwmOk, 1'b0);
    chk("R8", "stageRstN invalid pwm", stageRstN, 1'b0);
    chk("R8", "pwmEn invalid pwm", pwmEn, 1'b1);
    setPer(5, 4);
    cyc(40);
    chk("R2", "pwmOk period 9", pwmOk, 1'b0);
    curTag = "R8";
    setPer(5, 5);
    cyc(80);
    chk("R8", "stageRstN recovered", stageRstN, 1'b1);

    curTag = "R5";
    genMode = 2;
    cyc(30);
    chk("R5", "pwmStuck", pwmStuck, 1'b1);
    chk("R5", "pwmOk stuck", pwmOk, 1'b0);
    chk("R5", "stageRstN stuck", stageRstN, 1'b0);
    genMode = 1; ph = 0;
    cyc(80);

    curTag = "R4";
    genMode = 0;
    cyc(30);
    chk("R4", "pwmOk no edges", pwmOk, 1'b0);
    chk("R4", "pwmStuck low input", pwmStuck, 1'b0);
    genMode = 1; ph = 0;
    cyc(80);
    chk("R8", "stageRstN after timeout", stageRstN, 1'b1);

    curTag = "R9";
    shutdownReq = 1'b1;
    cyc(1);
    chk("R9", "stageRstN first", stageRstN, 1'b0);
    chk("R9", "pwmEn hold 0", pwmEn, 1'b1);
    cyc(1);
    chk("R9", "pwmEn hold 1", pwmEn, 1'b1);
    cyc(1);
    chk("R9", "pwmEn dropped", pwmEn, 1'b0);
    curTag = "R11";
    cyc(20);
    chk("R11", "pwmEn idle on shutdown", pwmEn, 1'b0);
    shutdownReq = 1'b0;
    cyc(PREC + 20);
    chk("R6", "stageRstN restart", stageRstN, 1'b1);

    curTag = "R9";
    bridgeGood = 1'b0;
    cyc(1);
    chk("R9", "stageRstN bridge loss", stageRstN, 1'b0);
    chk("R9", "pwmEn bridge loss", pwmEn, 1'b1);
    cyc(2);
    chk("R9", "pwmEn after hold", pwmEn, 1'b0);
    cyc(10);

    curTag = "R10";
    rstN = 1'b0; gateGood = 1'b0;
    cyc(2);
    rstN = 1'b1;
    cyc(2);
    bridgeGood = 1'b1;
    cyc(1);
    chk("R10", "seqErr set", seqErr, 1'b1);
    gateGood = 1'b1;
    cyc(PREC + 20);
    chk("R10", "seqErr sticky", seqErr, 1'b1);
    chk("R10", "pwmEn blocked", pwmEn, 1'b0);
    chk("R10", "stageRstN blocked", stageRstN, 1'b0);
    curTag = "R1";
    rstN = 1'b0;
    cyc(2);
    chk("R1", "seqErr cleared", seqErr, 1'b0);
    rstN = 1'b1;
    curTag = "R7";
    cyc(PREC + 30);
    chk("R7", "stageRstN after clean start", stageRstN, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule